// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the purely combinational control unit of a one-instruction-per-clock processor datapath. It takes the 6-bit primary opcode and the 6-bit function field of the current instruction. From them it produces every steering and enable signal the datapath needs in that same cycle:
- the destination-register select;
- the ALU second-operand select;
- the immediate extension mode;
- the write-back source select;
- the data-memory write enable;
- the register-file write enable;
- a 2-bit ALU operation code;
- the branch-on-equal and jump flags.

Seven instructions are decoded: register add and subtract without overflow trap, OR with immediate, load word, store word, branch-if-equal and absolute jump. The function field is consulted only when the opcode marks a register-format instruction. Any encoding outside the decoded set drives every output low. With all outputs low, nothing is written, no memory store happens and the program counter simply advances.

Top module: `sc_ctrl_decode`

## Requirements
- R1: Opcode 0x00 with funct 0x21 (register add) gives dst_sel_rd=1, alu_src_imm=0, ext_signed=0, mem_to_reg=0, mem_wr=0, reg_wr=1, alu_op=2'b00 (add), br_eq=0, jmp=0.
- R2: Opcode 0x00 with funct 0x23 (register subtract) gives the same outputs as R1 except alu_op=2'b01 (subtract).
- R3: Opcode 0x0D (OR immediate) gives dst_sel_rd=0, alu_src_imm=1, ext_signed=0 (zero extension), alu_op=2'b10 (OR), reg_wr=1, and all other outputs 0.
- R4: Opcode 0x23 (load word) gives dst_sel_rd=0, alu_src_imm=1, ext_signed=1, mem_to_reg=1, reg_wr=1, alu_op=2'b00, and all other outputs 0.
- R5: Opcode 0x2B (store word) gives alu_src_imm=1, ext_signed=1, mem_wr=1, alu_op=2'b00, and reg_wr=0 with all other outputs 0.
- R6: Opcode 0x04 (branch if equal) gives alu_src_imm=0, ext_signed=1, alu_op=2'b01, br_eq=1, with reg_wr=0, mem_wr=0 and all other outputs 0.
- R7: Opcode 0x02 (jump) gives jmp=1 and every other output 0.
- R8: Any opcode other than 0x00, 0x02, 0x04, 0x0D, 0x23 and 0x2B drives every output to 0.
- R9: Opcode 0x00 with any funct other than 0x21 or 0x23 drives every output to 0.
- R10: For every opcode other than 0x00, the outputs do not depend on the funct value.
- R11: At most one of mem_wr, br_eq and jmp is high. mem_to_reg high implies reg_wr high. mem_wr high implies reg_wr low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Primary opcode field of the instruction |
| fn_code | input | 6 | Function field, used for register-format only |
| dst_sel_rd | output | 1 | 1: write the rd field register; 0: the rt field |
| alu_src_imm | output | 1 | 1: ALU operand B is the extended immediate; 0: register read port B |
| ext_signed | output | 1 | 1: sign-extend the 16-bit immediate; 0: zero-extend |
| mem_to_reg | output | 1 | 1: write-back data comes from data memory; 0: from the ALU |
| mem_wr | output | 1 | Data-memory write enable |
| reg_wr | output | 1 | Register-file write enable |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |
| br_eq | output | 1 | Conditional branch taken when the ALU reports equality |
| jmp | output | 1 | Unconditional jump to the target field |

## Verification
The embedded assertions check, on every input change, the relations that hold for every encoding. These are the mutual exclusion of store, branch and jump; a write-back source only with a register write; and no register write alongside a store. They cannot say which encoding maps to which control word. The bench's scenarios show that mapping: each decoded instruction, the full sweep of unused opcodes and of unused function codes, and the insensitivity of immediate-format decoding to the funct bits.

// File: rtl/sc_ctrl_decode.sv
module sc_ctrl_decode #(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic [OP_W-1:0] op_code,
  input  logic [FN_W-1:0] fn_code,
  output logic            dst_sel_rd,
  output logic            alu_src_imm,
  output logic            ext_signed,
  output logic            mem_to_reg,
  output logic            mem_wr,
  output logic            reg_wr,
  output logic [1:0]      alu_op,
  output logic            br_eq,
  output logic            jmp
);

  localparam logic [OP_W-1:0] OP_RFMT = OP_W'(6'h00);
  localparam logic [OP_W-1:0] OP_JUMP = OP_W'(6'h02);
  localparam logic [OP_W-1:0] OP_BEQ  = OP_W'(6'h04);
  localparam logic [OP_W-1:0] OP_ORI  = OP_W'(6'h0D);
  localparam logic [OP_W-1:0] OP_LOAD = OP_W'(6'h23);
  localparam logic [OP_W-1:0] OP_STOR = OP_W'(6'h2B);
  localparam logic [FN_W-1:0] FN_ADD  = FN_W'(6'h21);
  localparam logic [FN_W-1:0] FN_SUB  = FN_W'(6'h23);

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_SUB = 2'b01;
  localparam logic [1:0] ALU_OR  = 2'b10;

  always_comb begin
    dst_sel_rd  = 1'b0;
    alu_src_imm = 1'b0;
    ext_signed  = 1'b0;
    mem_to_reg  = 1'b0;
    mem_wr      = 1'b0;
    reg_wr      = 1'b0;
    alu_op      = ALU_ADD;
    br_eq       = 1'b0;
    jmp         = 1'b0;
    unique case (op_code)
      OP_RFMT: begin
        if (fn_code == FN_ADD || fn_code == FN_SUB) begin
          dst_sel_rd = 1'b1;
          reg_wr     = 1'b1;
          alu_op     = (fn_code == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        alu_src_imm = 1'b1;
        alu_op      = ALU_OR;
        reg_wr      = 1'b1;
      end
      OP_LOAD: begin
        alu_src_imm = 1'b1;
        ext_signed  = 1'b1;
        mem_to_reg  = 1'b1;
        reg_wr      = 1'b1;
      end
      OP_STOR: begin
        alu_src_imm = 1'b1;
        ext_signed  = 1'b1;
        mem_wr      = 1'b1;
      end
      OP_BEQ: begin
        ext_signed = 1'b1;
        alu_op     = ALU_SUB;
        br_eq      = 1'b1;
      end
      OP_JUMP: jmp = 1'b1;
      default: ;
    endcase

    if (!$isunknown({op_code, fn_code})) begin
      // R11
      one_flow_chk: assert ($countones({mem_wr, br_eq, jmp}) <= 1)
        else $error("store, branch and jump overlap");
      // R11
      load_writes_chk: assert (!mem_to_reg || reg_wr)
        else $error("memory write-back without register write");
      // R5
      store_no_wb_chk: assert (!(mem_wr && reg_wr))
        else $error("store also writes a register");
      // R6
      branch_no_wb_chk: assert (!(br_eq && (reg_wr || alu_src_imm)))
        else $error("branch writes or uses immediate operand");
      // R7
      jump_quiet_chk: assert (!jmp || {reg_wr, mem_wr, alu_op} == 4'b0)
        else $error("jump drives datapath");
      // R3
      zext_or_chk: assert ((alu_op != ALU_OR) || !ext_signed)
        else $error("OR with sign extension");
    end
  end

endmodule

// File: tb/sc_ctrl_decode_bench.sv
module sc_ctrl_decode_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [5:0] op_code = 6'h00;
  logic [5:0] fn_code = 6'h00;
  logic dst_sel_rd, alu_src_imm, ext_signed, mem_to_reg, mem_wr, reg_wr, br_eq, jmp;
  logic [1:0] alu_op;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  sc_ctrl_decode u_sc_ctrl_decode (
    .op_code(op_code), .fn_code(fn_code),
    .dst_sel_rd(dst_sel_rd), .alu_src_imm(alu_src_imm), .ext_signed(ext_signed),
    .mem_to_reg(mem_to_reg), .mem_wr(mem_wr), .reg_wr(reg_wr),
    .alu_op(alu_op), .br_eq(br_eq), .jmp(jmp)
  );

  // Expected word: {rd, imm, sext, m2r, mwr, rwr, alu[1:0], br, j}
  localparam logic [9:0] E_ADD  = 10'b1_0_0_0_0_1_00_0_0;
  localparam logic [9:0] E_SUB  = 10'b1_0_0_0_0_1_01_0_0;
  localparam logic [9:0] E_ORI  = 10'b0_1_0_0_0_1_10_0_0;
  localparam logic [9:0] E_LW   = 10'b0_1_1_1_0_1_00_0_0;
  localparam logic [9:0] E_SW   = 10'b0_1_1_0_1_0_00_0_0;
  localparam logic [9:0] E_BEQ  = 10'b0_0_1_0_0_0_01_1_0;
  localparam logic [9:0] E_J    = 10'b0_0_0_0_0_0_00_0_1;
  localparam logic [9:0] E_NOP  = 10'b0;

  function automatic logic [9:0] got();
    return {dst_sel_rd, alu_src_imm, ext_signed, mem_to_reg, mem_wr, reg_wr, alu_op, br_eq, jmp};
  endfunction

  task automatic apply_chk(input logic [5:0] op, input logic [5:0] fn,
                           input logic [9:0] exp, input string req);
    @(negedge clk);
    op_code = op;
    fn_code = fn;
    @(posedge clk);
    #2;
    n_chk++;
    if (got() !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h fn=%h got=%b exp=%b", req, op, fn, got(), exp);
    end
  endtask

  function automatic bit legal_op(input logic [5:0] op);
    return op == 6'h00 || op == 6'h02 || op == 6'h04 ||
           op == 6'h0D || op == 6'h23 || op == 6'h2B;
  endfunction

  task automatic t_reset_state();
    apply_chk(6'h00, 6'h00, E_NOP, "R9 initial");
  endtask

  task automatic t_rformat();
    apply_chk(6'h00, 6'h21, E_ADD, "R1");
    apply_chk(6'h00, 6'h23, E_SUB, "R2");
    apply_chk(6'h00, 6'h21, E_ADD, "R1 after R2");
  endtask

  task automatic t_immediate();
    apply_chk(6'h0D, 6'h00, E_ORI, "R3");
    apply_chk(6'h23, 6'h00, E_LW,  "R4");
    apply_chk(6'h2B, 6'h00, E_SW,  "R5");
  endtask

  task automatic t_flow();
    apply_chk(6'h04, 6'h00, E_BEQ, "R6");
    apply_chk(6'h02, 6'h00, E_J,   "R7");
  endtask

  task automatic t_bad_ops();
    for (int i = 0; i < 64; i++)
      if (!legal_op(6'(i))) apply_chk(6'(i), 6'(i * 5), E_NOP, "R8");
  endtask

  task automatic t_bad_funct();
    for (int i = 0; i < 64; i++)
      if (i != 'h21 && i != 'h23) apply_chk(6'h00, 6'(i), E_NOP, "R9");
  endtask

  task automatic t_funct_ignored();
    apply_chk(6'h0D, 6'h23, E_ORI, "R10 ori");
    apply_chk(6'h23, 6'h21, E_LW,  "R10 lw");
    apply_chk(6'h2B, 6'h3F, E_SW,  "R10 sw");
    apply_chk(6'h04, 6'h23, E_BEQ, "R10 beq");
    apply_chk(6'h02, 6'h21, E_J,   "R10 j");
  endtask

  task automatic t_exclusive();
    logic [5:0] ops [6] = '{6'h00, 6'h02, 6'h04, 6'h0D, 6'h23, 6'h2B};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      op_code = ops[i];
      fn_code = 6'h23;
      @(posedge clk);
      #2;
      n_chk++;
      if ((int'(mem_wr) + int'(br_eq) + int'(jmp)) > 1 || (mem_to_reg && !reg_wr) ||
          (mem_wr && reg_wr)) begin
        n_bad++;
        $display("FAIL R11 op=%h got=%b exp=exclusive flags", ops[i], got());
      end
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset_state();
    t_rformat();
    t_immediate();
    t_flow();
    t_bad_ops();
    t_bad_funct();
    t_funct_ignored();
    t_exclusive();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule